// File: doc/BRIEF.md
# 16-bit Register-Pair Arithmetic Unit

This is a purely combinational arithmetic unit that serves the 16-bit register-pair operations of a small 8-bit processor core. It adds a source pair into a destination pair, steps a pair up or down by one, and adds a sign-extended 8-bit displacement to the stack pointer. A surrounding datapath presents the operands, a displacement byte, a mode code and the current flag nibble. The unit returns the 16-bit result and the next flag nibble in the same cycle.

Each operation has its own flag rule. The displacement operations differ most: their result is a signed 16-bit sum, but their half-carry and carry come from unsigned arithmetic on the low byte only. The displacement result can be written back to the stack pointer or to a different pair. A separate output tells the datapath which of the two destinations the current mode uses. Mode codes 5 to 7 are unused and pass the first operand and the flags through unchanged.

Top module: `pair_arith_unit`

## Requirements
- R1: In mode 0 (pair add), `sum_o` equals `lhs_i + rhs_i` modulo 65536. Any 16-bit value is accepted on `rhs_i`, so any of the two general pairs, the address pair or the stack pointer can be the source.
- R2: The flag nibble uses bit 3 = Z, bit 2 = N, bit 1 = H and bit 0 = C. In mode 0, Z is copied from `flags_i`, N is 0, H is the carry out of bit 11 and C is the carry out of bit 15.
- R3: Mode 1 (increment) gives `lhs_i + 1` and mode 2 (decrement) gives `lhs_i - 1`, both modulo 65536. So 0xFFFF steps up to 0x0000 and 0x0000 steps down to 0xFFFF.
- R4: In modes 1 and 2, `flags_o` equals `flags_i`.
- R5: In mode 3 (displacement to stack pointer) and mode 4 (displacement to another pair), `sum_o` equals `lhs_i` plus `disp_i` taken as an 8-bit two's-complement value sign-extended to 16 bits, modulo 65536.
- R6: In modes 3 and 4, Z and N are 0. H is the carry out of bit 3 of `lhs_i[7:0] + disp_i`, and C is the carry out of bit 7 of that same unsigned byte sum.
- R7: `to_sp_o` is 1 in mode 3 and 0 in every other mode.
- R8: In modes 5, 6 and 7, `sum_o` equals `lhs_i` and `flags_o` equals `flags_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lhs_i | input | 16 | Destination pair value, or the stack pointer in modes 3 and 4 |
| rhs_i | input | 16 | Source pair value for mode 0 |
| disp_i | input | 8 | Signed displacement byte for modes 3 and 4 |
| mode_i | input | 3 | Operation code: 0 add, 1 inc, 2 dec, 3 disp to SP, 4 disp to pair |
| flags_i | input | 4 | Current flags {Z,N,H,C} |
| sum_o | output | 16 | 16-bit result |
| flags_o | output | 4 | Next flags {Z,N,H,C} |
| to_sp_o | output | 1 | Result goes to the stack pointer |

## Verification
The displacement modes are swept over every combination of the stack pointer's low byte and the displacement byte, using several high bytes. This catches a design that takes H and C from the high-byte carries, or that zero-extends a negative displacement and so leaves the upper byte wrong. The pair add is swept over operands that place carries exactly at bits 11 and 15, which exposes a half-carry taken from bit 7 or a Z flag that is recomputed instead of kept. Increment and decrement are run over all 65536 values, so a missing wrap at the ends or any disturbance of the flags is reported. The unused codes are checked for leaked results and altered flags.

// File: rtl/pair_arith_pkg.sv
package pair_arith_pkg;

  localparam int unsigned PA_WIDTH  = 16;
  localparam int unsigned PA_DISP_W = 8;
  localparam int unsigned PA_MODE_W = 3;

  localparam logic [PA_MODE_W-1:0] MODE_PAIR_ADD  = 3'd0;
  localparam logic [PA_MODE_W-1:0] MODE_PAIR_INC  = 3'd1;
  localparam logic [PA_MODE_W-1:0] MODE_PAIR_DEC  = 3'd2;
  localparam logic [PA_MODE_W-1:0] MODE_DISP_SP   = 3'd3;
  localparam logic [PA_MODE_W-1:0] MODE_DISP_PAIR = 3'd4;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } pa_flags_t;

  typedef struct packed {
    logic add;
    logic step;
    logic disp;
    logic pass;
    logic to_sp;
  } pa_decode_t;

endpackage

// File: rtl/pair_operand_sel.sv
module pair_operand_sel
  import pair_arith_pkg::*;
#(
  parameter int unsigned WIDTH  = PA_WIDTH,
  parameter int unsigned DISP_W = PA_DISP_W
) (
  input  logic [PA_MODE_W-1:0] mode_i,
  input  logic [WIDTH-1:0]     rhs_i,
  input  logic [DISP_W-1:0]    disp_i,
  output pa_decode_t           dec_o,
  output logic [WIDTH-1:0]     addend_o
);

  localparam int unsigned EXT_W = WIDTH - DISP_W;

  logic [WIDTH-1:0] disp_ext;
  logic [WIDTH-1:0] step_one;
  logic [WIDTH-1:0] step_minus;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    end else begin : g_noext
      assign disp_ext = disp_i[WIDTH-1:0];
    end
  endgenerate

  assign step_one   = {{(WIDTH-1){1'b0}}, 1'b1};
  assign step_minus = {WIDTH{1'b1}};

  always_comb begin
    dec_o       = '0;
    addend_o    = '0;
    unique case (mode_i)
      MODE_PAIR_ADD: begin
        dec_o.add = 1'b1;
        addend_o  = rhs_i;
      end
      MODE_PAIR_INC: begin
        dec_o.step = 1'b1;
        addend_o   = step_one;
      end
      MODE_PAIR_DEC: begin
        dec_o.step = 1'b1;
        addend_o   = step_minus;
      end
      MODE_DISP_SP: begin
        dec_o.disp  = 1'b1;
        dec_o.to_sp = 1'b1;
        addend_o    = disp_ext;
      end
      MODE_DISP_PAIR: begin
        dec_o.disp = 1'b1;
        addend_o   = disp_ext;
      end
      default: begin
        dec_o.pass = 1'b1;
      end
    endcase
  end

  // One operation class per mode; only mode 3 steers to the stack pointer.
  always_comb begin
    p_one_class_r8: assert ($countones({dec_o.add, dec_o.step, dec_o.disp, dec_o.pass}) == 1)
      else $error("decode class not unique");
    p_sp_dest_r7: assert (!dec_o.to_sp || (mode_i == MODE_DISP_SP))
      else $error("stack pointer destination outside mode 3");
  end

endmodule

// File: rtl/pair_carry_chain.sv
module pair_carry_chain #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH-1:0] cout_o
);

  logic [WIDTH:0]   full;
  logic [WIDTH-1:0] cin;

  assign full  = {1'b0, a_i} + {1'b0, b_i};
  assign sum_o = full[WIDTH-1:0];
  assign cin   = full[WIDTH-1:0] ^ a_i ^ b_i;

  // cout_o[i] is the carry leaving bit i.
  generate
    for (genvar i = 0; i < WIDTH - 1; i++) begin : g_cout
      assign cout_o[i] = cin[i+1];
    end
  endgenerate
  assign cout_o[WIDTH-1] = full[WIDTH];

endmodule

// File: rtl/pair_flag_gen.sv
module pair_flag_gen
  import pair_arith_pkg::*;
#(
  parameter int unsigned WIDTH  = PA_WIDTH,
  parameter int unsigned DISP_W = PA_DISP_W
) (
  input  pa_decode_t       dec_i,
  input  pa_flags_t        flags_i,
  input  logic [WIDTH-1:0] cout_i,
  output pa_flags_t        flags_o
);

  localparam int unsigned PAIR_H_BIT = WIDTH - 5;
  localparam int unsigned PAIR_C_BIT = WIDTH - 1;
  localparam int unsigned DISP_H_BIT = (DISP_W / 2) - 1;
  localparam int unsigned DISP_C_BIT = DISP_W - 1;

  always_comb begin
    flags_o = flags_i;
    if (dec_i.add) begin
      flags_o.n = 1'b0;
      flags_o.h = cout_i[PAIR_H_BIT];
      flags_o.c = cout_i[PAIR_C_BIT];
    end else if (dec_i.disp) begin
      flags_o.z = 1'b0;
      flags_o.n = 1'b0;
      flags_o.h = cout_i[DISP_H_BIT];
      flags_o.c = cout_i[DISP_C_BIT];
    end
  end

  always_comb begin
    p_add_keeps_z_r2: assert (!dec_i.add || (flags_o.z == flags_i.z && !flags_o.n))
      else $error("pair add disturbed Z or set N");
    p_step_flags_r4: assert (!dec_i.step || (flags_o == flags_i))
      else $error("increment/decrement changed flags");
    p_disp_zn_r6: assert (!dec_i.disp || (!flags_o.z && !flags_o.n))
      else $error("displacement mode left Z or N set");
    p_pass_flags_r8: assert (!dec_i.pass || (flags_o == flags_i))
      else $error("unused mode changed flags");
  end

endmodule

// File: rtl/pair_arith_unit.sv
module pair_arith_unit
  import pair_arith_pkg::*;
(
  input  logic [15:0] lhs_i,
  input  logic [15:0] rhs_i,
  input  logic [7:0]  disp_i,
  input  logic [2:0]  mode_i,
  input  logic [3:0]  flags_i,
  output logic [15:0] sum_o,
  output logic [3:0]  flags_o,
  output logic        to_sp_o
);

  localparam int unsigned WIDTH  = PA_WIDTH;
  localparam int unsigned DISP_W = PA_DISP_W;

  pa_decode_t       dec;
  logic [WIDTH-1:0] addend;
  logic [WIDTH-1:0] raw_sum;
  logic [WIDTH-1:0] cout;
  pa_flags_t        flags_nxt;

  pair_operand_sel #(.WIDTH(WIDTH), .DISP_W(DISP_W)) u_sel (
    .mode_i   (mode_i),
    .rhs_i    (rhs_i),
    .disp_i   (disp_i),
    .dec_o    (dec),
    .addend_o (addend)
  );

  pair_carry_chain #(.WIDTH(WIDTH)) u_chain (
    .a_i    (lhs_i),
    .b_i    (addend),
    .sum_o  (raw_sum),
    .cout_o (cout)
  );

  pair_flag_gen #(.WIDTH(WIDTH), .DISP_W(DISP_W)) u_flags (
    .dec_i   (dec),
    .flags_i (pa_flags_t'(flags_i)),
    .cout_i  (cout),
    .flags_o (flags_nxt)
  );

  assign sum_o   = dec.pass ? lhs_i : raw_sum;
  assign flags_o = flags_nxt;
  assign to_sp_o = dec.to_sp;

  always_comb begin
    p_inc_wrap_r3: assert (!(mode_i == MODE_PAIR_INC && lhs_i == 16'hFFFF) || sum_o == 16'h0000)
      else $error("increment did not wrap");
    p_dec_wrap_r3: assert (!(mode_i == MODE_PAIR_DEC && lhs_i == 16'h0000) || sum_o == 16'hFFFF)
      else $error("decrement did not wrap");
    p_disp_low_r5: assert (!dec.disp || sum_o[7:0] == 8'(lhs_i[7:0] + disp_i))
      else $error("displacement low byte wrong");
  end

endmodule

// File: tb/sim_pair_arith_unit.sv
module sim_pair_arith_unit;

  logic        clk;
  logic        rst_n;
  logic [15:0] lhs, rhs;
  logic [7:0]  disp;
  logic [2:0]  mode;
  logic [3:0]  fin;
  logic [15:0] sum;
  logic [3:0]  fout;
  logic        to_sp;

  int n_cmp;
  int n_bad;
  int cycles;
  bit done;

  pair_arith_unit u0 (
    .lhs_i   (lhs),
    .rhs_i   (rhs),
    .disp_i  (disp),
    .mode_i  (mode),
    .flags_i (fin),
    .sum_o   (sum),
    .flags_o (fout),
    .to_sp_o (to_sp)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp=completion", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic cmp16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      if (n_bad < 20)
        $display("FAIL %s: mode=%0d lhs=%h rhs=%h disp=%h act=%h exp=%h",
                 tag, mode, lhs, rhs, disp, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] m, input logic [15:0] a, input logic [15:0] b,
                       input logic [7:0] d, input logic [3:0] f);
    mode = m; lhs = a; rhs = b; disp = d; fin = f;
    #1;
  endtask

  task automatic chk_add(input logic [15:0] a, input logic [15:0] b, input logic [3:0] f);
    logic [16:0] s;
    logic [12:0] hs;
    apply(3'd0, a, b, 8'h5A, f);
    s  = {1'b0, a} + {1'b0, b};
    hs = {1'b0, a[11:0]} + {1'b0, b[11:0]};
    cmp16("R1", sum, s[15:0]);
    cmp16("R2", {12'd0, fout}, {12'd0, f[3], 1'b0, hs[12], s[16]});
  endtask

  task automatic chk_disp(input logic [2:0] m, input logic [15:0] a, input logic [7:0] d,
                          input logic [3:0] f);
    logic [15:0] ext;
    logic [8:0]  lb;
    logic [4:0]  ln;
    apply(m, a, 16'h1234, d, f);
    ext = d[7] ? (16'hFF00 | {8'd0, d}) : {8'd0, d};
    lb  = {1'b0, a[7:0]} + {1'b0, d};
    ln  = {1'b0, a[3:0]} + {1'b0, d[3:0]};
    cmp16("R5", sum, a + ext);
    cmp16("R6", {12'd0, fout}, {12'd0, 2'b00, ln[4], lb[8]});
    cmp16("R7", {15'd0, to_sp}, {15'd0, (m == 3'd3)});
  endtask

  initial begin
    rst_n = 1'b0; cycles = 0; done = 1'b0; n_cmp = 0; n_bad = 0;
    mode = 3'd7; lhs = '0; rhs = '0; disp = '0; fin = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Idle state at start: pass-through code, all zero inputs (R8)
    cmp16("R8", sum, 16'h0000);
    cmp16("R8", {12'd0, fout}, 16'h0000);

    // R1/R2: carries placed at bit 11 and bit 15 boundaries
    chk_add(16'h0FFF, 16'h0001, 4'b1000);
    chk_add(16'hFFFF, 16'h0001, 4'b0111);
    chk_add(16'h8000, 16'h8000, 4'b1111);
    chk_add(16'h0800, 16'h0800, 4'b0000);
    chk_add(16'h07FF, 16'h0800, 4'b0101);
    for (int i = 0; i < 64; i++)
      for (int j = 0; j < 64; j++)
        chk_add(16'(i * 1031), 16'(j * 1021 + 7), 4'(i ^ j));

    // R3/R4: exhaustive increment and decrement
    for (int v = 0; v < 65536; v++) begin
      apply(3'd1, 16'(v), 16'hAAAA, 8'h80, 4'(v));
      cmp16("R3", sum, 16'(v + 1));
      cmp16("R4", {12'd0, fout}, {12'd0, 4'(v)});
      cmp16("R7", {15'd0, to_sp}, 16'd0);
      apply(3'd2, 16'(v), 16'h5555, 8'h7F, 4'(v >> 4));
      cmp16("R3", sum, 16'(v - 1));
      cmp16("R4", {12'd0, fout}, {12'd0, 4'(v >> 4)});
    end

    // R5/R6/R7: all low-byte / displacement pairs for several high bytes
    for (int hb = 0; hb < 4; hb++)
      for (int lo = 0; lo < 256; lo++)
        for (int d = 0; d < 256; d++)
          chk_disp((((lo + d) & 1) != 0) ? 3'd3 : 3'd4,
                   {8'(hb * 85), 8'(lo)}, 8'(d), 4'b1111);
    chk_disp(3'd3, 16'h0000, 8'hFF, 4'b1100);
    chk_disp(3'd4, 16'hFFFF, 8'h01, 4'b1100);

    // R8: unused codes
    for (int m = 5; m < 8; m++) begin
      apply(3'(m), 16'hBEEF, 16'h1111, 8'h22, 4'b1010);
      cmp16("R8", sum, 16'hBEEF);
      cmp16("R8", {12'd0, fout}, 16'h000A);
      cmp16("R7", {15'd0, to_sp}, 16'd0);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule